// File: doc/BRIEF.md
# Page Access Permission and Fault Code Unit

This unit sits at the end of a page-table walk. It takes the no-execute, user and writable bits collected from every paging level, together with the kind of access and the current mode controls. From these it decides, one clock after a request, whether the access raises a page fault. If it does, the unit produces the fault code word. If it does not, it produces the read, write and execute rights to install in a translation cache entry.

A per-level enable mask selects which levels take part, so one instance serves both short and long table formats. The walker reports a missing entry or a reserved-bit violation on its own input, and the unit folds these into the same fault code. The walker, the memory port and the translation cache storage live outside this unit.

Top module: `pg_perm_unit`

## Requirements
- R1: Only levels whose `lvl_en` bit is 1 take part. The effective no-execute bit is 1 when any enabled level has its NX bit set and `nxe_en` is 1; when `nxe_en` is 0, NX bits have no effect. The effective user and writable bits are 1 only when every enabled level has them set.
- R2: An instruction fetch (`acc_type` = 2) to a page whose effective no-execute bit is 1 is a protection fault.
- R3: A user-mode access to a page whose effective user bit is 0 is a protection fault. A user-mode write (`acc_type` = 1) to a page whose effective writable bit is 0 is also a protection fault.
- R4: A supervisor write to a page whose effective writable bit is 0 faults only when `wp_en` is 1.
- R5: Fault code bit 0 (present) is 1 for a protection fault. It is 0 when `walk_np` reports a missing entry, and it is 0 when `walk_rsvd` reports a reserved-bit violation. Bit 3 is 1 for a reserved-bit fault.
- R6: On any fault, fault code bit 1 is 1 for a write and bit 2 is 1 for a user-mode access.
- R7: Fault code bit 4 is 1 only for a faulting fetch while `nxe_en` and `ext_en` are both 1.
- R8: On a non-faulting access, `perm_r` is 1 and `perm_x` is the inverse of the effective no-execute bit.
- R9: `perm_w` is 1 only when `leaf_dirty` is 1 and there is no fault. In addition, a user access needs the effective writable bit, and a supervisor access needs the effective writable bit or `wp_en` = 0.
- R10: Results appear one clock after a cycle with `req_valid` = 1, with `rsp_valid` = 1. After a cycle without a request, `rsp_valid` is 0 and the other outputs keep their values. Reset clears all outputs to 0.
- R11: An `acc_type` of 3 is handled exactly as a read.
- R12: `walk_np` takes priority over `walk_rsvd`, and `walk_rsvd` takes priority over protection checks. On a fault all three rights are 0. Without a fault the fault code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| lvl_en | input | LEVELS | Levels taking part in the check |
| lvl_nx | input | LEVELS | No-execute bit per level |
| lvl_usr | input | LEVELS | User bit per level |
| lvl_wr | input | LEVELS | Writable bit per level |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| user_mode | input | 1 | Access made at user privilege |
| wp_en | input | 1 | Supervisor write protection enabled |
| nxe_en | input | 1 | No-execute enforcement enabled |
| ext_en | input | 1 | Extended paging mode enabled |
| leaf_dirty | input | 1 | Leaf entry already dirty |
| walk_np | input | 1 | Walker found a missing entry |
| walk_rsvd | input | 1 | Walker found a reserved-bit violation |
| rsp_valid | output | 1 | Result valid |
| fault | output | 1 | Access faults |
| fault_code | output | 5 | Fault code word |
| perm_r | output | 1 | Read right |
| perm_w | output | 1 | Write right |
| perm_x | output | 1 | Execute right |

## Verification
Every result is due exactly one rising edge after the request is presented, because the logic holds a single register stage between inputs and outputs. The bench drives each request at a falling edge and pushes the result its model predicts into a queue. At the next falling edge, after the capturing rising edge, it pops that entry and compares it with all outputs. Idle cycles push the previous outputs with the valid flag cleared, so the hold behaviour is checked on the same cadence.

// File: rtl/pg_perm_pkg.sv
package pg_perm_pkg;

  localparam int unsigned FC_W       = 5;
  localparam int unsigned FC_PRESENT = 0;
  localparam int unsigned FC_WRITE   = 1;
  localparam int unsigned FC_USER    = 2;
  localparam int unsigned FC_RSVD    = 3;
  localparam int unsigned FC_FETCH   = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic nx;
    logic usr;
    logic wr;
  } eff_bits_t;

  typedef struct packed {
    logic            fault;
    logic [FC_W-1:0] code;
    logic            r;
    logic            w;
    logic            x;
  } chk_result_t;

endpackage

// File: rtl/pg_level_merge.sv
module pg_level_merge
  import pg_perm_pkg::*;
#(
  parameter int unsigned LEVELS = 4
) (
  input  logic [LEVELS-1:0] lvl_en,
  input  logic [LEVELS-1:0] lvl_nx,
  input  logic [LEVELS-1:0] lvl_usr,
  input  logic [LEVELS-1:0] lvl_wr,
  input  logic              nxe_en,
  output eff_bits_t         eff
);

  logic [LEVELS:0] nx_c;
  logic [LEVELS:0] usr_c;
  logic [LEVELS:0] wr_c;

  assign nx_c[0]  = 1'b0;
  assign usr_c[0] = 1'b1;
  assign wr_c[0]  = 1'b1;

  // Restrictions accumulate one level at a time; a disabled level is transparent.
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign nx_c[g+1]  = nx_c[g]  | (lvl_en[g] & lvl_nx[g]);
    assign usr_c[g+1] = usr_c[g] & (~lvl_en[g] | lvl_usr[g]);
    assign wr_c[g+1]  = wr_c[g]  & (~lvl_en[g] | lvl_wr[g]);
  end

  always_comb begin
    eff.nx  = nx_c[LEVELS] & nxe_en;
    eff.usr = usr_c[LEVELS];
    eff.wr  = wr_c[LEVELS];
  end

endmodule

// File: rtl/pg_access_judge.sv
module pg_access_judge
  import pg_perm_pkg::*;
(
  input  eff_bits_t  eff,
  input  logic [1:0] acc_type,
  input  logic       user_mode,
  input  logic       wp_en,
  output logic       is_write,
  output logic       is_fetch,
  output logic       prot_fault
);

  acc_kind_e kind;
  logic      fetch_blocked;
  logic      user_blocked;
  logic      sup_blocked;

  always_comb begin
    kind     = acc_kind_e'(acc_type);
    is_write = (kind == ACC_WRITE);
    is_fetch = (kind == ACC_FETCH);

    fetch_blocked = is_fetch & eff.nx;
    user_blocked  = user_mode & (~eff.usr | (is_write & ~eff.wr));
    sup_blocked   = ~user_mode & wp_en & is_write & ~eff.wr;

    prot_fault = fetch_blocked | user_blocked | sup_blocked;
  end

endmodule

// File: rtl/pg_fault_encode.sv
module pg_fault_encode
  import pg_perm_pkg::*;
(
  input  eff_bits_t   eff,
  input  logic        prot_fault,
  input  logic        is_write,
  input  logic        is_fetch,
  input  logic        user_mode,
  input  logic        wp_en,
  input  logic        nxe_en,
  input  logic        ext_en,
  input  logic        leaf_dirty,
  input  logic        walk_np,
  input  logic        walk_rsvd,
  output chk_result_t res
);

  logic rsvd_only;
  logic prot_only;
  logic any_fault;
  logic wr_ok;

  always_comb begin
    rsvd_only = walk_rsvd & ~walk_np;
    prot_only = prot_fault & ~walk_np & ~walk_rsvd;
    any_fault = walk_np | walk_rsvd | prot_fault;

    wr_ok = user_mode ? eff.wr : (eff.wr | ~wp_en);

    res       = '0;
    res.fault = any_fault;
    if (any_fault) begin
      res.code[FC_PRESENT] = prot_only;
      res.code[FC_WRITE]   = is_write;
      res.code[FC_USER]    = user_mode;
      res.code[FC_RSVD]    = rsvd_only;
      res.code[FC_FETCH]   = is_fetch & nxe_en & ext_en;
    end else begin
      res.r = 1'b1;
      res.x = ~eff.nx;
      res.w = leaf_dirty & wr_ok;
    end
  end

endmodule

// File: rtl/pg_perm_unit.sv
module pg_perm_unit
  import pg_perm_pkg::*;
#(
  parameter int unsigned LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LEVELS-1:0] lvl_en,
  input  logic [LEVELS-1:0] lvl_nx,
  input  logic [LEVELS-1:0] lvl_usr,
  input  logic [LEVELS-1:0] lvl_wr,
  input  logic [1:0]        acc_type,
  input  logic              user_mode,
  input  logic              wp_en,
  input  logic              nxe_en,
  input  logic              ext_en,
  input  logic              leaf_dirty,
  input  logic              walk_np,
  input  logic              walk_rsvd,
  output logic              rsp_valid,
  output logic              fault,
  output logic [FC_W-1:0]   fault_code,
  output logic              perm_r,
  output logic              perm_w,
  output logic              perm_x
);

  eff_bits_t   eff;
  logic        is_write;
  logic        is_fetch;
  logic        prot_fault;
  chk_result_t res_d;
  chk_result_t res_q;
  chk_result_t res_nxt;
  logic        vld_q;
  logic        vld_nxt;

  pg_level_merge #(.LEVELS(LEVELS)) u_merge (
    .lvl_en  (lvl_en),
    .lvl_nx  (lvl_nx),
    .lvl_usr (lvl_usr),
    .lvl_wr  (lvl_wr),
    .nxe_en  (nxe_en),
    .eff     (eff)
  );

  pg_access_judge u_judge (
    .eff        (eff),
    .acc_type   (acc_type),
    .user_mode  (user_mode),
    .wp_en      (wp_en),
    .is_write   (is_write),
    .is_fetch   (is_fetch),
    .prot_fault (prot_fault)
  );

  pg_fault_encode u_enc (
    .eff        (eff),
    .prot_fault (prot_fault),
    .is_write   (is_write),
    .is_fetch   (is_fetch),
    .user_mode  (user_mode),
    .wp_en      (wp_en),
    .nxe_en     (nxe_en),
    .ext_en     (ext_en),
    .leaf_dirty (leaf_dirty),
    .walk_np    (walk_np),
    .walk_rsvd  (walk_rsvd),
    .res        (res_d)
  );

  // Next-state: load on a request, otherwise hold.
  always_comb begin
    vld_nxt = req_valid;
    res_nxt = res_q;
    if (req_valid) begin
      res_nxt = res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_nxt;
      res_q <= res_nxt;
    end
  end

  assign rsp_valid  = vld_q;
  assign fault      = res_q.fault;
  assign fault_code = res_q.code;
  assign perm_r     = res_q.r;
  assign perm_w     = res_q.w;
  assign perm_x     = res_q.x;

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> ($stable(fault_code) && $stable(fault)));

  assert_read_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fault) |-> perm_r);

  assert_no_rights_on_fault_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault) |-> (!perm_r && !perm_w && !perm_x));

  assert_clean_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fault) |-> (fault_code == '0));

  assert_missing_not_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(walk_np)) |-> (fault && !fault_code[FC_PRESENT]));

  assert_user_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault) |-> (fault_code[FC_USER] == $past(user_mode)));

  assert_fetch_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault_code[FC_FETCH]) |->
      ($past(acc_type) == 2'd2 && $past(nxe_en) && $past(ext_en)));

  assert_wr_needs_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && perm_w) |-> $past(leaf_dirty));

endmodule

// File: tb/pg_perm_unit_tb_top.sv
module pg_perm_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LV = 4;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [LV-1:0] lvl_en, lvl_nx, lvl_usr, lvl_wr;
  logic [1:0]    acc_type;
  logic          user_mode, wp_en, nxe_en, ext_en, leaf_dirty, walk_np, walk_rsvd;
  logic          rsp_valid, fault, perm_r, perm_w, perm_x;
  logic [4:0]    fault_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // packed expectation: {valid, fault, code[4:0], r, w, x}
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [9:0] last_out;

  pg_perm_unit #(.LEVELS(LV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .lvl_en(lvl_en), .lvl_nx(lvl_nx), .lvl_usr(lvl_usr), .lvl_wr(lvl_wr),
    .acc_type(acc_type), .user_mode(user_mode), .wp_en(wp_en),
    .nxe_en(nxe_en), .ext_en(ext_en), .leaf_dirty(leaf_dirty),
    .walk_np(walk_np), .walk_rsvd(walk_rsvd),
    .rsp_valid(rsp_valid), .fault(fault), .fault_code(fault_code),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8:0] model(
    logic [LV-1:0] en, logic [LV-1:0] nx, logic [LV-1:0] us, logic [LV-1:0] rw,
    logic [1:0] acc, logic usr, logic wp, logic nxe, logic ext, logic dirty,
    logic np, logic rsv);
    logic enx, eu, ew, wr, fe, prot, flt;
    logic [4:0] code;
    logic r, w, x;
    enx = 0; eu = 1; ew = 1;
    for (int i = 0; i < LV; i++) begin
      if (en[i]) begin
        if (nx[i]) enx = 1;
        if (!us[i]) eu = 0;
        if (!rw[i]) ew = 0;
      end
    end
    if (!nxe) enx = 0;
    wr = (acc == 2'd1);
    fe = (acc == 2'd2);
    prot = (fe && enx) || (usr && (!eu || (wr && !ew))) || (!usr && wp && wr && !ew);
    flt = np || rsv || prot;
    code = 5'd0; r = 0; w = 0; x = 0;
    if (flt) begin
      code[0] = !np && !rsv;
      code[1] = wr;
      code[2] = usr;
      code[3] = rsv && !np;
      code[4] = fe && nxe && ext;
    end else begin
      r = 1;
      x = !enx;
      w = dirty && (usr ? ew : (ew || !wp));
    end
    return {flt, code, r, w, x};
  endfunction

  task automatic check_out();
    logic [9:0] act, exp;
    string t;
    act = {rsp_valid, fault, fault_code, perm_r, perm_w, perm_x};
    if (exp_q.size() == 0) return;
    exp = exp_q.pop_front();
    t = tag_q.pop_front();
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", t, act, exp);
    end
    last_out = act;
  endtask

  task automatic apply(logic [LV-1:0] en, logic [LV-1:0] nx, logic [LV-1:0] us,
                       logic [LV-1:0] rw, logic [1:0] acc, logic usr, logic wp,
                       logic nxe, logic ext, logic dirty, logic np, logic rsv,
                       string t);
    logic [8:0] m;
    req_valid = 1; lvl_en = en; lvl_nx = nx; lvl_usr = us; lvl_wr = rw;
    acc_type = acc; user_mode = usr; wp_en = wp; nxe_en = nxe; ext_en = ext;
    leaf_dirty = dirty; walk_np = np; walk_rsvd = rsv;
    m = model(en, nx, us, rw, acc, usr, wp, nxe, ext, dirty, np, rsv);
    exp_q.push_back({1'b1, m});
    tag_q.push_back(t);
    @(negedge clk);
    check_out();
  endtask

  task automatic idle(string t);
    logic [9:0] e;
    req_valid = 0;
    // scramble other inputs: they must not reach the outputs
    acc_type = 2'd2; walk_np = 1; user_mode = 1;
    e = last_out;
    e[9] = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    check_out();
  endtask

  initial begin
    rst_n = 0; req_valid = 0; lvl_en = '0; lvl_nx = '0; lvl_usr = '0; lvl_wr = '0;
    acc_type = 0; user_mode = 0; wp_en = 0; nxe_en = 0; ext_en = 0;
    leaf_dirty = 0; walk_np = 0; walk_rsvd = 0; last_out = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    exp_q.push_back(10'd0); tag_q.push_back("R10 reset");
    check_out();
    rst_n = 1;
    @(negedge clk);

    // R2 fetch, NX on one level, extended mode on -> code 0x11
    apply(4'hF, 4'b0100, 4'hF, 4'hF, 2'd2, 0, 0, 1, 1, 0, 0, 0, "R2");
    // R7 same without extended mode -> code 0x01
    apply(4'hF, 4'b0100, 4'hF, 4'hF, 2'd2, 0, 0, 1, 0, 0, 0, 0, "R7");
    // R1 nxe off: NX ignored, fetch allowed, exec right set
    apply(4'hF, 4'b0100, 4'hF, 4'hF, 2'd2, 0, 0, 0, 1, 0, 0, 0, "R1");
    // R1 NX only on a disabled level
    apply(4'b0011, 4'b1000, 4'hF, 4'hF, 2'd2, 0, 0, 1, 1, 0, 0, 0, "R1");
    // R1 user bit missing on disabled level, user read ok
    apply(4'b0111, 4'b0000, 4'b0111, 4'hF, 2'd0, 1, 1, 1, 1, 1, 0, 0, "R1");
    // R3 user read, user bit clear -> code 0x05
    apply(4'hF, 4'b0000, 4'b1101, 4'hF, 2'd0, 1, 0, 1, 1, 0, 0, 0, "R3");
    // R3 user write, writable clear -> code 0x07
    apply(4'hF, 4'b0000, 4'hF, 4'b1110, 2'd1, 1, 0, 1, 1, 1, 0, 0, "R3");
    // R4 supervisor write, read-only, wp off -> ok, dirty gives write right
    apply(4'hF, 4'b0000, 4'hF, 4'b0111, 2'd1, 0, 0, 1, 1, 1, 0, 0, "R4");
    // R4 same with wp on -> code 0x03
    apply(4'hF, 4'b0000, 4'hF, 4'b0111, 2'd1, 0, 1, 1, 1, 1, 0, 0, "R4");
    // R9 user write to clean writable page: no fault, no write right
    apply(4'hF, 4'b0000, 4'hF, 4'hF, 2'd1, 1, 1, 1, 1, 0, 0, 0, "R9");
    // R9 user read, dirty, writable -> write right
    apply(4'hF, 4'b0000, 4'hF, 4'hF, 2'd0, 1, 1, 1, 1, 1, 0, 0, "R9");
    // R11 type 3 user on read-only page: read, no fault
    apply(4'hF, 4'b0000, 4'hF, 4'b0000, 2'd3, 1, 1, 1, 1, 1, 0, 0, "R11");
    // R8 exec right cleared by NX on a read
    apply(4'hF, 4'b0001, 4'hF, 4'hF, 2'd0, 0, 0, 1, 1, 1, 0, 0, "R8");
    // R5 missing entry -> present clear
    apply(4'hF, 4'b0000, 4'hF, 4'hF, 2'd1, 1, 0, 1, 1, 0, 1, 0, "R5");
    // R5 reserved -> bit 3
    apply(4'hF, 4'b0000, 4'hF, 4'hF, 2'd0, 0, 0, 1, 1, 0, 0, 1, "R5");
    // R12 missing beats reserved and protection
    apply(4'hF, 4'b1111, 4'h0, 4'h0, 2'd2, 1, 1, 1, 1, 1, 1, 1, "R12");
    // R6 supervisor fault code flags
    apply(4'hF, 4'b0000, 4'hF, 4'hF, 2'd1, 0, 0, 0, 0, 0, 0, 1, "R6");
    // R10 hold on idle cycles
    idle("R10 hold");
    idle("R10 hold");

    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom();
      if (r[31:29] == 3'd0) begin
        idle("R10 idle");
      end else begin
        apply(r[3:0], r[7:4], r[11:8] | {4{r[28]}}, r[15:12] | {4{r[27]}},
              r[17:16], r[18], r[19], r[20], r[21], r[22],
              r[23] & r[24] & r[25], r[26] & r[24] & r[25], "R12 mixed");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule